// File: doc/BRIEF.md
# Pixel Colour Matrix with Offsets

This block is a streaming colour-space conversion stage for pixels with three 12-bit channels. Each input channel first receives its own signed pre-offset. The stage then forms three output channels as weighted sums of the three offset inputs. Each output is rounded, receives its own signed post-offset, and is clamped to 0..4095. The nine weights use a compact 16-bit floating code: a sign, a 3-bit scale code and a 9-bit mantissa. The scale code slides the mantissa's binary point across six octaves, so one 9-bit mantissa covers both small and large weights. A mode bit can route the pixel around the arithmetic without changing the latency.

Software loads the weights, offsets and mode through a plain write port into a shadow bank. A small state machine with two states, `CFG_CLEAN` and `CFG_DIRTY`, tracks whether the shadow bank differs from the active bank.
- `CFG_CLEAN` moves to `CFG_DIRTY` on any write.
- `CFG_DIRTY` returns to `CFG_CLEAN` on a frame-start pulse that carries no write. That pulse copies the shadow bank into the active bank.
- `CFG_DIRTY` stays in `CFG_DIRTY` when the frame-start pulse carries a write. The copy still happens, but the new write lands only in the shadow bank.

Because the copy happens only at frame start, no frame ever sees a half-updated set of weights. Pixels flow with a fixed latency and no back-pressure.

Top module: `csc_matrix_top`

## Requirements
- R1: During and after reset, `out_valid` is low until pixels arrive. The active and shadow banks reset to an identity matrix with zero offsets and bypass off, so an input pixel comes out unchanged.
- R2: `out_valid` equals `pix_in_valid` delayed by exactly 3 clock cycles.
- R3: A weight word holds the sign in bit 15, the scale code in bits 14:12 and the mantissa m in bits 11:3. Bits 2:0 are ignored. The weight magnitude in units of 1/4096 is: m for code 3, 2m for code 2, 4m for code 1, 8m for code 0, 16m for code 7 and 32m for code 6. Codes 4 and 5 give zero. A set sign negates the weight.
- R4: Each output channel k is computed as floor((sum over j of w[k][j]*(in[j]+pre[j]) + 2048) / 4096) + post[k]. Output channel 0 is in bits 11:0, channel 1 in bits 23:12 and channel 2 in bits 35:24. Input channels are packed the same way.
- R5: Register map. Address 2k holds the weight of input 0 for output k in bits 31:16 and the weight of input 1 in bits 15:0. Address 2k+1 holds the weight of input 2 in bits 31:16; its bits 15:0 are ignored. Addresses 6, 7 and 8 hold the pre-offsets of inputs 0, 1 and 2. Addresses 9, 10 and 11 hold the post-offsets of outputs 0, 1 and 2. Bit 0 of address 12 is the bypass bit.
- R6: Pre-offsets and post-offsets are 13-bit two's-complement values in bits 12:0, in pixel LSBs, so full scale is 4096. For example, a post-offset of 0x101 lifts black to 257.
- R7: Any result below 0 is output as 0, and any result above 4095 is output as 4095.
- R8: Writes change only the shadow bank. A frame-start pulse copies the shadow bank, as it stood before that cycle's write, into the active bank. A write in the same cycle as frame start therefore takes effect only at the following frame start.
- R9: With the active bypass bit set, the output pixel equals the input pixel, with the same latency and no offsets applied.
- R10: Writes to addresses 13, 14 and 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | One-cycle pulse that loads the shadow bank into the active bank |
| pix_in_valid | input | 1 | Input pixel qualifier |
| pix_in_data | input | 36 | Input pixel, channel 0 in the low 12 bits |
| out_valid | output | 1 | Output pixel qualifier |
| pix_out | output | 36 | Output pixel, channel 0 in the low 12 bits |

## Verification
A register write and a frame-start pulse can fall in the same cycle. In that cycle the shadow copy and the shadow update compete. The bench provokes this case in three steps:
1. It leaves one weight pending in the shadow bank.
2. It drives frame start together with a write that gives the same weight a second value.
3. It checks that the next pixel uses the earlier value, and that the pixel after the following frame start uses the later value.

Assertions also check that the active bank after a frame-start pulse equals the shadow bank before it.

// File: rtl/csc_pkg.sv
package csc_pkg;
    localparam int CSC_CH      = 3;
    localparam int COEF_W      = 16;
    localparam int GUARD_W     = 3;
    localparam int MANT_W      = 9;
    localparam int EXP_W       = 3;
    localparam int COEF_FLD_W  = COEF_W - GUARD_W;
    localparam int MAX_SHIFT   = 5;
    localparam int MAG_W       = MANT_W + MAX_SHIFT;
    localparam int COEF_VAL_W  = MAG_W + 1;
    localparam int FRAC_W      = MANT_W + 3;
    localparam int OFS_W       = 13;
    localparam int CFG_ADDR_W  = 4;
    localparam int CFG_DATA_W  = 32;
    localparam int ADDR_PRE0   = 2 * CSC_CH;
    localparam int ADDR_POST0  = ADDR_PRE0 + CSC_CH;
    localparam int ADDR_MODE   = ADDR_POST0 + CSC_CH;
    localparam logic [COEF_W-1:0] COEF_ONE = 16'h7800;

    typedef enum logic [0:0] {
        CFG_CLEAN = 1'b0,
        CFG_DIRTY = 1'b1
    } cfg_state_e;

    typedef struct packed {
        logic [CSC_CH*CSC_CH-1:0][COEF_W-1:0] coef;
        logic [CSC_CH-1:0][OFS_W-1:0]         pre;
        logic [CSC_CH-1:0][OFS_W-1:0]         post;
        logic                                 bypass;
    } csc_cfg_t;

    function automatic csc_cfg_t csc_cfg_default();
        csc_cfg_t c;
        c = '0;
        for (int i = 0; i < CSC_CH; i++) begin
            c.coef[i*CSC_CH+i] = COEF_ONE;
        end
        return c;
    endfunction
endpackage

// File: rtl/csc_coef_dec.sv
module csc_coef_dec
    import csc_pkg::*;
(
    input  logic [COEF_FLD_W-1:0]        fld,
    output logic signed [COEF_VAL_W-1:0] val
);
    logic             sgn;
    logic [EXP_W-1:0] code;
    logic [MANT_W-1:0] mant;
    logic [MAG_W-1:0] mag;

    assign sgn  = fld[COEF_FLD_W-1];
    assign code = fld[COEF_FLD_W-2 -: EXP_W];
    assign mant = fld[MANT_W-1:0];

    // Scale code slides the mantissa across six octaves.
    always_comb begin
        unique case (code)
            3'd3:    mag = MAG_W'(mant);
            3'd2:    mag = MAG_W'(mant) << 1;
            3'd1:    mag = MAG_W'(mant) << 2;
            3'd0:    mag = MAG_W'(mant) << 3;
            3'd7:    mag = MAG_W'(mant) << 4;
            3'd6:    mag = MAG_W'(mant) << 5;
            default: mag = '0;
        endcase
    end

    always_comb begin
        if (sgn) val = -$signed({1'b0, mag});
        else     val =  $signed({1'b0, mag});
    end
endmodule

// File: rtl/csc_cfg_bank.sv
module csc_cfg_bank
    import csc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [CFG_DATA_W-1:0] cfg_wdata,
    input  logic                  frame_start,
    output csc_cfg_t              shd_cfg,
    output csc_cfg_t              act_cfg
);
    cfg_state_e state_q, state_d;
    logic       load_act;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_CLEAN;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_CLEAN: if (cfg_we) state_d = CFG_DIRTY;
            CFG_DIRTY: if (frame_start && !cfg_we) state_d = CFG_CLEAN;
            default:   state_d = CFG_CLEAN;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        load_act = 1'b0;
        unique case (state_q)
            CFG_CLEAN: load_act = 1'b0;
            CFG_DIRTY: load_act = frame_start;
            default:   load_act = 1'b0;
        endcase
    end

    // Shadow bank: written directly by the register port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_cfg <= csc_cfg_default();
        end else if (cfg_we) begin
            for (int r = 0; r < CSC_CH; r++) begin
                if (cfg_addr == CFG_ADDR_W'(2*r)) begin
                    shd_cfg.coef[r*CSC_CH]   <= cfg_wdata[31:16];
                    shd_cfg.coef[r*CSC_CH+1] <= cfg_wdata[15:0];
                end
                if (cfg_addr == CFG_ADDR_W'(2*r+1)) begin
                    shd_cfg.coef[r*CSC_CH+2] <= cfg_wdata[31:16];
                end
                if (cfg_addr == CFG_ADDR_W'(ADDR_PRE0+r)) begin
                    shd_cfg.pre[r] <= cfg_wdata[OFS_W-1:0];
                end
                if (cfg_addr == CFG_ADDR_W'(ADDR_POST0+r)) begin
                    shd_cfg.post[r] <= cfg_wdata[OFS_W-1:0];
                end
            end
            if (cfg_addr == CFG_ADDR_W'(ADDR_MODE)) begin
                shd_cfg.bypass <= cfg_wdata[0];
            end
        end
    end

    // Active bank: copied from the shadow at frame start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        act_cfg <= csc_cfg_default();
        else if (load_act) act_cfg <= shd_cfg;
    end
endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
    import csc_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid,
    input  logic [CSC_CH*PIX_W-1:0]               in_data,
    input  logic [CSC_CH*CSC_CH-1:0][COEF_FLD_W-1:0] coef_fld,
    input  logic [CSC_CH-1:0][OFS_W-1:0]          pre_ofs,
    input  logic [CSC_CH-1:0][OFS_W-1:0]          post_ofs,
    input  logic                                  bypass,
    output logic                                  out_valid,
    output logic [CSC_CH*PIX_W-1:0]               out_data
);
    localparam int X_W  = (((PIX_W + 1) > OFS_W) ? (PIX_W + 1) : OFS_W) + 1;
    localparam int P_W  = X_W + COEF_VAL_W;
    localparam int S_W  = P_W + $clog2(CSC_CH);
    localparam int NCOEF = CSC_CH * CSC_CH;
    localparam logic signed [S_W-1:0] HALF    = S_W'(2**(FRAC_W-1));
    localparam logic signed [S_W-1:0] PIX_MAX = S_W'((2**PIX_W) - 1);

    logic signed [COEF_VAL_W-1:0] cval [NCOEF];

    for (genvar k = 0; k < NCOEF; k++) begin : g_dec
        csc_coef_dec u_dec (
            .fld (coef_fld[k]),
            .val (cval[k])
        );
    end

    // Stage 1: pre-offset
    logic                       s1_val;
    logic [CSC_CH*PIX_W-1:0]    s1_raw;
    logic signed [X_W-1:0]      s1_x   [CSC_CH];
    logic signed [X_W-1:0]      x_d    [CSC_CH];

    always_comb begin
        for (int c = 0; c < CSC_CH; c++) begin
            x_d[c] = $signed({{(X_W-PIX_W){1'b0}}, in_data[c*PIX_W +: PIX_W]})
                   + $signed({{(X_W-OFS_W){pre_ofs[c][OFS_W-1]}}, pre_ofs[c]});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_val <= 1'b0;
            s1_raw <= '0;
            for (int c = 0; c < CSC_CH; c++) s1_x[c] <= '0;
        end else begin
            s1_val <= in_valid;
            s1_raw <= in_data;
            for (int c = 0; c < CSC_CH; c++) s1_x[c] <= x_d[c];
        end
    end

    // Stage 2: matrix products and row sums
    logic                       s2_val;
    logic [CSC_CH*PIX_W-1:0]    s2_raw;
    logic signed [S_W-1:0]      s2_sum [CSC_CH];
    logic signed [S_W-1:0]      sum_d  [CSC_CH];

    always_comb begin
        logic signed [P_W-1:0] prod;
        logic signed [S_W-1:0] acc;
        for (int r = 0; r < CSC_CH; r++) begin
            acc = '0;
            for (int j = 0; j < CSC_CH; j++) begin
                prod = P_W'(s1_x[j]) * P_W'(cval[r*CSC_CH+j]);
                acc  = acc + S_W'(prod);
            end
            sum_d[r] = acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_val <= 1'b0;
            s2_raw <= '0;
            for (int r = 0; r < CSC_CH; r++) s2_sum[r] <= '0;
        end else begin
            s2_val <= s1_val;
            s2_raw <= s1_raw;
            for (int r = 0; r < CSC_CH; r++) s2_sum[r] <= sum_d[r];
        end
    end

    // Stage 3: round, post-offset, clamp, bypass select
    logic [CSC_CH*PIX_W-1:0] out_d;

    always_comb begin
        logic signed [S_W-1:0] t;
        out_d = '0;
        for (int r = 0; r < CSC_CH; r++) begin
            t = (s2_sum[r] + HALF) >>> FRAC_W;
            t = t + S_W'($signed(post_ofs[r]));
            if (bypass)            out_d[r*PIX_W +: PIX_W] = s2_raw[r*PIX_W +: PIX_W];
            else if (t < 0)        out_d[r*PIX_W +: PIX_W] = '0;
            else if (t > PIX_MAX)  out_d[r*PIX_W +: PIX_W] = PIX_MAX[PIX_W-1:0];
            else                   out_d[r*PIX_W +: PIX_W] = t[PIX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s2_val;
            out_data  <= out_d;
        end
    end
endmodule

// File: rtl/csc_matrix_top.sv
module csc_matrix_top
    import csc_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [CFG_ADDR_W-1:0]   cfg_addr,
    input  logic [CFG_DATA_W-1:0]   cfg_wdata,
    input  logic                    frame_start,
    input  logic                    pix_in_valid,
    input  logic [CSC_CH*PIX_W-1:0] pix_in_data,
    output logic                    out_valid,
    output logic [CSC_CH*PIX_W-1:0] pix_out
);
    csc_cfg_t cfg_shd;
    csc_cfg_t cfg_act;
    logic [CSC_CH*CSC_CH-1:0][COEF_FLD_W-1:0] coef_fld;

    csc_cfg_bank u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .frame_start (frame_start),
        .shd_cfg     (cfg_shd),
        .act_cfg     (cfg_act)
    );

    for (genvar k = 0; k < CSC_CH*CSC_CH; k++) begin : g_fld
        assign coef_fld[k] = cfg_act.coef[k][COEF_W-1:GUARD_W];
    end

    csc_datapath #(.PIX_W(PIX_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (pix_in_valid),
        .in_data   (pix_in_data),
        .coef_fld  (coef_fld),
        .pre_ofs   (cfg_act.pre),
        .post_ofs  (cfg_act.post),
        .bypass    (cfg_act.bypass),
        .out_valid (out_valid),
        .out_data  (pix_out)
    );
endmodule

// File: rtl/csc_matrix_chk.sv
module csc_matrix_chk
    import csc_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    frame_start,
    input logic                    pix_in_valid,
    input logic [CSC_CH*PIX_W-1:0] pix_in_data,
    input logic                    out_valid,
    input logic [CSC_CH*PIX_W-1:0] pix_out,
    input csc_cfg_t                act,
    input csc_cfg_t                shad
);
    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    // R1: reset keeps the output qualifier low
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R2: fixed three-cycle latency of the qualifier
    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |-> (out_valid == $past(pix_in_valid, 3)));

    // R8: active bank stays put between frame starts
    assert_active_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(act));

    // R8: frame start copies the pre-write shadow bank
    assert_active_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (act == $past(shad)));

    // R9: bypass forwards the delayed input pixel
    assert_bypass_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && out_valid && $past(act.bypass)) |-> (pix_out == $past(pix_in_data, 3)));
endmodule

bind csc_matrix_top csc_matrix_chk #(.PIX_W(PIX_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .pix_in_valid (pix_in_valid),
    .pix_in_data  (pix_in_data),
    .out_valid    (out_valid),
    .pix_out      (pix_out),
    .act          (cfg_act),
    .shad         (cfg_shd)
);

// File: tb/csc_matrix_top_tb_top.sv
module csc_matrix_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PIX_W      = 12;
    localparam int NVEC       = 12;

    // {weight word, input channel 0, expected output channel 0}
    localparam logic [39:0] VEC [NVEC] = '{
        {16'h7800, 12'd1000, 12'd1000},
        {16'h6800, 12'd1000, 12'd2000},
        {16'h0800, 12'd1000, 12'd500},
        {16'h1800, 12'd1000, 12'd250},
        {16'h2800, 12'd1000, 12'd125},
        {16'h3800, 12'd1000, 12'd63},
        {16'hF800, 12'd1000, 12'd0},
        {16'h6FF8, 12'd4095, 12'd4095},
        {16'h4800, 12'd1000, 12'd0},
        {16'h7807, 12'd1000, 12'd1000},
        {16'h7C00, 12'd1000, 12'd1500},
        {16'h0FF8, 12'd4095, 12'd4087}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        pix_in_valid = 1'b0;
    logic [35:0] pix_in_data = '0;
    logic        out_valid;
    logic [35:0] pix_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [15:0] m_coef [9];
    logic [12:0] m_pre  [3];
    logic [12:0] m_post [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    csc_matrix_top #(.PIX_W(PIX_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .frame_start  (frame_start),
        .pix_in_valid (pix_in_valid),
        .pix_in_data  (pix_in_data),
        .out_valid    (out_valid),
        .pix_out      (pix_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sx13(input logic [12:0] v);
        return v[12] ? int'(v) - 8192 : int'(v);
    endfunction

    function automatic int dec(input logic [15:0] w);
        int m;
        int v;
        m = int'(w[11:3]);
        case (w[14:12])
            3'd3: v = m;
            3'd2: v = m * 2;
            3'd1: v = m * 4;
            3'd0: v = m * 8;
            3'd7: v = m * 16;
            3'd6: v = m * 32;
            default: v = 0;
        endcase
        return w[15] ? -v : v;
    endfunction

    function automatic int model(input int k, input int a, input int b, input int c);
        int x [3];
        int acc;
        int t;
        x[0] = a; x[1] = b; x[2] = c;
        acc = 0;
        for (int j = 0; j < 3; j++) acc += dec(m_coef[k*3+j]) * (x[j] + sx13(m_pre[j]));
        t = (acc + 2048) >>> 12;
        t = t + sx13(m_post[k]);
        if (t < 0) t = 0;
        if (t > 4095) t = 4095;
        return t;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic frame_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        frame_start = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        frame_start = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic pix(input int a, input int b, input int c, output logic [35:0] o);
        @(negedge clk);
        pix_in_valid = 1'b1;
        pix_in_data  = {12'(c), 12'(b), 12'(a)};
        @(negedge clk);
        pix_in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        o = pix_out;
    endtask

    task automatic push_cfg(input logic bypass);
        for (int r = 0; r < 3; r++) begin
            wr(4'(2*r), {m_coef[3*r], m_coef[3*r+1]});
            wr(4'(2*r+1), {m_coef[3*r+2], 16'hBEEF});
        end
        for (int c = 0; c < 3; c++) begin
            wr(4'(6+c), {19'd0, m_pre[c]});
            wr(4'(9+c), {19'd0, m_post[c]});
        end
        wr(4'd12, {31'd0, bypass});
        frame();
    endtask

    task automatic set_identity();
        for (int i = 0; i < 9; i++) m_coef[i] = (i % 4 == 0) ? 16'h7800 : 16'h0000;
        for (int c = 0; c < 3; c++) begin m_pre[c] = '0; m_post[c] = '0; end
    endtask

    task automatic check_model(input string tag, input int a, input int b, input int c);
        logic [35:0] o;
        pix(a, b, c, o);
        check(tag, int'(o[11:0]),  model(0, a, b, c));
        check(tag, int'(o[23:12]), model(1, a, b, c));
        check(tag, int'(o[35:24]), model(2, a, b, c));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [35:0] o;
        repeat (3) @(negedge clk);
        check("R1 valid low in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid low after reset", int'(out_valid), 0);

        // R1: reset bank is identity
        pix(100, 2000, 4095, o);
        check("R1 identity ch0", int'(o[11:0]), 100);
        check("R1 identity ch1", int'(o[23:12]), 2000);
        check("R1 identity ch2", int'(o[35:24]), 4095);

        // R2: latency of the qualifier
        @(negedge clk);
        pix_in_valid = 1'b1; pix_in_data = 36'h1;
        @(negedge clk);
        pix_in_valid = 1'b0;
        check("R2 valid at +1", int'(out_valid), 0);
        @(negedge clk);
        check("R2 valid at +2", int'(out_valid), 0);
        @(negedge clk);
        check("R2 valid at +3", int'(out_valid), 1);
        @(negedge clk);
        check("R2 valid at +4", int'(out_valid), 0);

        // R3: weight decode table, output 0 row, inputs 1 and 2 zero
        for (int v = 0; v < NVEC; v++) begin
            wr(4'd0, {VEC[v][39:24], 16'h0000});
            frame();
            pix(int'(VEC[v][23:12]), 0, 0, o);
            check("R3 decode ch0", int'(o[11:0]), int'(VEC[v][11:0]));
            check("R3 decode ch1", int'(o[23:12]), 0);
        end

        // R4 R5 R6: full matrix with offsets
        m_coef[0] = 16'h1B68; m_coef[1] = 16'h0B70; m_coef[2] = 16'h3938;
        m_coef[3] = 16'h9A60; m_coef[4] = 16'hAAA8; m_coef[5] = 16'h0800;
        m_coef[6] = 16'h0800; m_coef[7] = 16'h8AE8; m_coef[8] = 16'hBA50;
        m_pre[0]  = 13'h0000; m_pre[1]  = 13'h1FF0; m_pre[2]  = 13'h0040;
        m_post[0] = 13'h0800; m_post[1] = 13'h0100; m_post[2] = 13'h0800;
        push_cfg(1'b0);
        check_model("R4 R5 matrix red",   4095, 0, 0);
        check_model("R4 R5 matrix green", 0, 4095, 0);
        check_model("R4 R6 matrix mixed", 1234, 2345, 3456);
        check_model("R4 R6 matrix black", 0, 0, 0);

        // R9: bypass forwards the pixel untouched
        push_cfg(1'b1);
        pix(11, 2222, 4000, o);
        check("R9 bypass ch0", int'(o[11:0]), 11);
        check("R9 bypass ch1", int'(o[23:12]), 2222);
        check("R9 bypass ch2", int'(o[35:24]), 4000);
        wr(4'd12, 32'd0);
        frame();
        check_model("R9 bypass off", 500, 600, 700);

        // R7: clamping at both ends
        set_identity();
        m_pre[0] = 13'h1F9C;
        m_post[1] = 13'h0FFF;
        push_cfg(1'b0);
        pix(50, 100, 7, o);
        check("R7 clamp low", int'(o[11:0]), 0);
        check("R7 clamp high", int'(o[23:12]), 4095);
        check("R7 pass middle", int'(o[35:24]), 7);

        // R6: limited-range black level
        set_identity();
        for (int c = 0; c < 3; c++) m_post[c] = 13'h0101;
        push_cfg(1'b0);
        pix(0, 0, 0, o);
        check("R6 black ch0", int'(o[11:0]), 257);
        check("R6 black ch2", int'(o[35:24]), 257);

        // R8: double buffering and write on the frame-start cycle
        set_identity();
        push_cfg(1'b0);
        wr(4'd0, {16'h6800, 16'h0000});
        pix(300, 0, 0, o);
        check("R8 pending not used", int'(o[11:0]), 300);
        frame_wr(4'd0, {16'h0800, 16'h0000});
        pix(300, 0, 0, o);
        check("R8 same-cycle write excluded", int'(o[11:0]), 600);
        frame();
        pix(300, 0, 0, o);
        check("R8 later frame takes write", int'(o[11:0]), 150);

        // R10: unmapped addresses
        set_identity();
        push_cfg(1'b0);
        wr(4'd13, 32'hFFFF_FFFF);
        wr(4'd14, 32'hFFFF_FFFF);
        wr(4'd15, 32'hFFFF_FFFF);
        frame();
        pix(7, 8, 9, o);
        check("R10 unmapped ch0", int'(o[11:0]), 7);
        check("R10 unmapped ch1", int'(o[23:12]), 8);
        check("R10 unmapped ch2", int'(o[35:24]), 9);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule